// File: doc/BRIEF.md
# Parallel Receive Sampling Window Controller

This block decides, cycle by cycle, which beats of an incoming parallel bus are captured and when a receive frame closes. One of the data lines, picked by an index, acts as the external enable. The block can run in three ways. In level mode, that line qualifies capture while it holds a chosen polarity. In pulse mode, one-cycle pulses on that line open and close the frame. In software mode, a software enable input qualifies capture. A frame closes in one of three ways: a byte count is reached, the enable line says so, or an inactivity timeout fires. The timeout closes the frame with an error end-of-frame.

Configuration inputs are copied into a shadow set only when the load strobe is high. The `arm` strobe starts a frame, and it also restarts a frame that is still running. The captured-beat qualifier `sample_en` is a valid-only stream marker with no ready. The byte packer behind it must accept every beat flagged in the cycle it is flagged, so no back-pressure exists. The outputs are combinational from the registered state and the current inputs. Each captured beat adds `BEAT_BYTES` bytes to the frame count.

Top module: `rx_window_ctrl`

## Requirements
- R1: After reset, and in any idle cycle without `arm`, `sample_en`, `eof` and `err_eof` are all low. The cycle in which `arm` is high is idle as well.
- R2: The shadow configuration changes only on a clock edge with `cfg_load` high. Its reset values are: mode level (0), level polarity 0, submode 0, end select 0, length 0, enable line 15, timeout enabled, threshold 4095.
- R3: Mode 0 (level) captures every busy cycle in which the enable line is high when `cfg_lvl_pol`=0, or low when it is 1.
- R4: Mode 2 (software) captures every busy cycle in which `sw_en` is high. Mode 3 never captures.
- R5: Mode 1 (pulse) waits for a start pulse. Submodes 0–5 take a high enable line as a pulse, and submodes 6–11 take a low one. With k = submode mod 6, the start cycle itself is captured when k is 0, 1 or 4.
- R6: In pulse submodes with k<4, every cycle after the start pulse is captured until the next pulse. That pulse raises `eof`, and it is captured only when k is even.
- R7: Pulse submodes with k=4 or 5 capture every cycle after the start, pulses included, and end only by length. Submodes 12–15 never start a frame.
- R8: End by length applies to the length submodes, and to level or software mode with `cfg_eof_sel`=0. It raises `eof` on the capture that brings the byte count to or past `cfg_len`. The next cycle is idle.
- R9: In level or software mode with `cfg_eof_sel`=1, `eof` is raised on the first non-capturing cycle after at least one capture.
- R10: When the timeout is enabled, `err_eof` is raised on the busy non-capturing cycle that makes the run of non-capturing cycles since the last capture or `arm` reach `cfg_to_thresh`. The threshold counts as at least 1. The next cycle is idle. When the timeout is disabled, `err_eof` never rises.
- R11: `eof` and `err_eof` are never high together. When both conditions hold, `eof` wins. `err_eof` never rises in a capturing cycle.
- R12: `arm` clears the byte and inactivity counts and starts a new frame, even if a frame is running.
- R13: The enable line is `data_in[cfg_en_sel]` of the shadow set. All other lines have no effect on capture or frame end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_in | input | BUS_W | Raw parallel data lines |
| arm | input | 1 | Start or restart a frame |
| sw_en | input | 1 | Software capture enable (mode 2) |
| cfg_load | input | 1 | Copy configuration inputs into the shadow set |
| cfg_mode | input | 2 | 0 level, 1 pulse, 2 software |
| cfg_lvl_pol | input | 1 | Level mode: 0 capture on high, 1 on low |
| cfg_submode | input | 4 | Pulse submode 0..11 |
| cfg_eof_sel | input | 1 | Level/software: 0 end by length, 1 end by enable |
| cfg_len | input | LEN_W | Frame length in bytes |
| cfg_en_sel | input | SEL_W | Index of the enable line |
| cfg_to_en | input | 1 | Timeout enable |
| cfg_to_thresh | input | TO_W | Timeout threshold in cycles |
| sample_en | output | 1 | Current beat is captured |
| eof | output | 1 | Frame ended normally this cycle |
| err_eof | output | 1 | Frame ended by timeout this cycle |

## Verification
A normal end and a timeout can fall in the same cycle. One case is level mode with end-by-enable and a threshold of 1: the first inactive cycle after a capture both ends the frame and completes the inactivity run. The other case is an excluded end pulse that arrives just as the run reaches the threshold. The bench provokes both and expects `eof` alone, with `err_eof` low, followed by an idle cycle. A behavioural model compares all three outputs on every clock.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

  typedef enum logic [1:0] {
    SMP_LEVEL = 2'd0,
    SMP_PULSE = 2'd1,
    SMP_SOFT  = 2'd2,
    SMP_RSVD  = 2'd3
  } smp_mode_e;

  typedef enum logic [1:0] {
    FR_IDLE = 2'd0,
    FR_WAIT = 2'd1,
    FR_RUN  = 2'd2
  } fr_state_e;

  typedef struct packed {
    logic valid;
    logic neg;
    logic start_inc;
    logic end_inc;
    logic by_len;
  } pulse_kind_t;

  // Submode table: low half positive pulses, high half negative; within each
  // group of six, k<4 are pulse-ended include/exclude pairs, k>=4 length-ended.
  function automatic pulse_kind_t decode_pulse(input logic [3:0] code);
    pulse_kind_t r;
    logic [3:0] k;
    r.valid = (code < 4'd12);
    r.neg   = (code >= 4'd6) && r.valid;
    k       = r.neg ? code - 4'd6 : code;
    r.by_len    = (k >= 4'd4);
    r.start_inc = r.by_len ? (k == 4'd4) : (k < 4'd2);
    r.end_inc   = ~k[0];
    return r;
  endfunction

endpackage

// File: rtl/rxw_cfg_shadow.sv
module rxw_cfg_shadow
  import rxw_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int TO_W  = 16,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [1:0]       in_mode,
  input  logic             in_lvl_pol,
  input  logic [3:0]       in_submode,
  input  logic             in_eof_sel,
  input  logic [LEN_W-1:0] in_len,
  input  logic [SEL_W-1:0] in_sel,
  input  logic             in_to_en,
  input  logic [TO_W-1:0]  in_thresh,
  output smp_mode_e        sh_mode,
  output logic             sh_lvl_pol,
  output logic [3:0]       sh_submode,
  output logic             sh_eof_sel,
  output logic [LEN_W-1:0] sh_len,
  output logic [SEL_W-1:0] sh_sel,
  output logic             sh_to_en,
  output logic [TO_W-1:0]  sh_thresh
);

  localparam logic [TO_W-1:0] THRESH_RST = TO_W'(4095);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_mode    <= SMP_LEVEL;
      sh_lvl_pol <= 1'b0;
      sh_submode <= '0;
      sh_eof_sel <= 1'b0;
      sh_len     <= '0;
      sh_sel     <= '1;
      sh_to_en   <= 1'b1;
      sh_thresh  <= THRESH_RST;
    end else if (load) begin
      sh_mode    <= smp_mode_e'(in_mode);
      sh_lvl_pol <= in_lvl_pol;
      sh_submode <= in_submode;
      sh_eof_sel <= in_eof_sel;
      sh_len     <= in_len;
      sh_sel     <= in_sel;
      sh_to_en   <= in_to_en;
      sh_thresh  <= in_thresh;
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(sh_mode) && $stable(sh_submode) && $stable(sh_len)
               && $stable(sh_sel) && $stable(sh_thresh) && $stable(sh_to_en))); // R2

endmodule

// File: rtl/rxw_counters.sv
module rxw_counters #(
  parameter int LEN_W      = 16,
  parameter int TO_W       = 16,
  parameter int BEAT_BYTES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             cap,
  input  logic             busy,
  input  logic [LEN_W-1:0] len,
  input  logic [TO_W-1:0]  thresh,
  output logic             len_hit,
  output logic             to_hit
);

  localparam int CNT_W = LEN_W + 2;
  localparam logic [CNT_W-1:0] STEP = CNT_W'(BEAT_BYTES);

  logic [CNT_W-1:0] bytes_q;
  logic [TO_W-1:0]  idle_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bytes_q <= '0;
      idle_q  <= '0;
    end else if (arm) begin
      bytes_q <= '0;
      idle_q  <= '0;
    end else if (cap) begin
      bytes_q <= bytes_q + STEP;
      idle_q  <= '0;
    end else if (busy && (idle_q != '1)) begin
      idle_q  <= idle_q + 1'b1;
    end
  end

  assign len_hit = (bytes_q + STEP) >= CNT_W'(len);
  assign to_hit  = ({1'b0, idle_q} + 1'b1) >= {1'b0, thresh};

  AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (bytes_q == '0) && (idle_q == '0)); // R12
  AST_CAP_RESTARTS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && !arm) |=> (idle_q == '0)); // R10

endmodule

// File: rtl/rxw_frame_fsm.sv
module rxw_frame_fsm
  import rxw_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      arm,
  input  logic      en_line,
  input  logic      sw_en,
  input  smp_mode_e mode,
  input  logic      lvl_pol,
  input  logic [3:0] submode,
  input  logic      eof_sel,
  input  logic      to_en,
  input  logic      len_hit,
  input  logic      to_hit,
  output logic      busy,
  output logic      cap,
  output logic      eof,
  output logic      err
);

  fr_state_e   st_q, st_d;
  logic        seen_q, seen_d;
  logic        qual;
  logic        hit;
  pulse_kind_t kind;

  assign kind = decode_pulse(submode);
  assign busy = (st_q != FR_IDLE);
  assign hit  = en_line ^ kind.neg;
  assign qual = (mode == SMP_LEVEL) ? (en_line ^ lvl_pol) : sw_en;

  always_comb begin
    st_d   = st_q;
    seen_d = seen_q;
    cap    = 1'b0;
    eof    = 1'b0;
    err    = 1'b0;
    if (arm) begin
      st_d   = FR_WAIT;
      seen_d = 1'b0;
    end else if (busy) begin
      unique case (mode)
        SMP_LEVEL, SMP_SOFT: begin
          cap = qual;
          eof = eof_sel ? (!qual && seen_q) : (qual && len_hit);
        end
        SMP_PULSE: begin
          if (st_q == FR_WAIT) begin
            if (kind.valid && hit) begin
              st_d = FR_RUN;
              cap  = kind.start_inc;
              eof  = kind.by_len && kind.start_inc && len_hit;
            end
          end else if (!kind.by_len && hit) begin
            cap = kind.end_inc;
            eof = 1'b1;
          end else begin
            cap = 1'b1;
            eof = kind.by_len && len_hit;
          end
        end
        default: ;
      endcase
      err = !cap && !eof && to_en && to_hit;
      if (cap) seen_d = 1'b1;
      if (eof || err) st_d = FR_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FR_IDLE;
      seen_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      seen_q <= seen_d;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FR_IDLE || arm) |-> !(cap || eof || err)); // R1
  AST_END_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((eof || err) && !arm) |=> (st_q == FR_IDLE)); // R8
  AST_ARM_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (st_q == FR_WAIT)); // R12

endmodule

// File: rtl/rx_window_ctrl.sv
module rx_window_ctrl
  import rxw_pkg::*;
#(
  parameter int BUS_W      = 16,
  parameter int LEN_W      = 16,
  parameter int TO_W       = 16,
  parameter int BEAT_BYTES = 2,
  parameter int SEL_W      = $clog2(BUS_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] data_in,
  input  logic             arm,
  input  logic             sw_en,
  input  logic             cfg_load,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_lvl_pol,
  input  logic [3:0]       cfg_submode,
  input  logic             cfg_eof_sel,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic [SEL_W-1:0] cfg_en_sel,
  input  logic             cfg_to_en,
  input  logic [TO_W-1:0]  cfg_to_thresh,
  output logic             sample_en,
  output logic             eof,
  output logic             err_eof
);

  smp_mode_e        sh_mode;
  logic             sh_lvl_pol;
  logic [3:0]       sh_submode;
  logic             sh_eof_sel;
  logic [LEN_W-1:0] sh_len;
  logic [SEL_W-1:0] sh_sel;
  logic             sh_to_en;
  logic [TO_W-1:0]  sh_thresh;
  logic             en_line;
  logic             busy, len_hit, to_hit;

  rxw_cfg_shadow #(.LEN_W(LEN_W), .TO_W(TO_W), .SEL_W(SEL_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .load(cfg_load),
    .in_mode(cfg_mode), .in_lvl_pol(cfg_lvl_pol), .in_submode(cfg_submode),
    .in_eof_sel(cfg_eof_sel), .in_len(cfg_len), .in_sel(cfg_en_sel),
    .in_to_en(cfg_to_en), .in_thresh(cfg_to_thresh),
    .sh_mode(sh_mode), .sh_lvl_pol(sh_lvl_pol), .sh_submode(sh_submode),
    .sh_eof_sel(sh_eof_sel), .sh_len(sh_len), .sh_sel(sh_sel),
    .sh_to_en(sh_to_en), .sh_thresh(sh_thresh)
  );

  assign en_line = data_in[sh_sel];

  rxw_counters #(.LEN_W(LEN_W), .TO_W(TO_W), .BEAT_BYTES(BEAT_BYTES)) u_cnt (
    .clk(clk), .rst_n(rst_n), .arm(arm), .cap(sample_en), .busy(busy),
    .len(sh_len), .thresh(sh_thresh), .len_hit(len_hit), .to_hit(to_hit)
  );

  rxw_frame_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .arm(arm), .en_line(en_line), .sw_en(sw_en),
    .mode(sh_mode), .lvl_pol(sh_lvl_pol), .submode(sh_submode),
    .eof_sel(sh_eof_sel), .to_en(sh_to_en), .len_hit(len_hit), .to_hit(to_hit),
    .busy(busy), .cap(sample_en), .eof(eof), .err(err_eof)
  );

  AST_EOF_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(eof && err_eof)); // R11
  AST_ERR_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    err_eof |-> !sample_en); // R11
  AST_ERR_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_eof |-> sh_to_en); // R10

endmodule

// File: tb/rx_window_ctrl_bench.sv
module rx_window_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] data_in = '0;
  logic        arm = 1'b0, sw_en = 1'b0, cfg_load = 1'b0;
  logic [1:0]  cfg_mode = '0;
  logic        cfg_lvl_pol = 1'b0, cfg_eof_sel = 1'b0, cfg_to_en = 1'b1;
  logic [3:0]  cfg_submode = '0, cfg_en_sel = 4'd15;
  logic [15:0] cfg_len = '0, cfg_to_thresh = 16'd4095;
  logic        sample_en, eof, err_eof;

  int checks = 0, errors = 0;

  // behavioural model state
  int m_st, m_bytes, m_idle;
  bit m_seen;
  int m_mode, m_sub, m_len, m_sel, m_thr;
  bit m_pol, m_esel, m_toen;

  always #5 clk = ~clk;

  rx_window_ctrl u_rx_window_ctrl (
    .clk(clk), .rst_n(rst_n), .data_in(data_in), .arm(arm), .sw_en(sw_en),
    .cfg_load(cfg_load), .cfg_mode(cfg_mode), .cfg_lvl_pol(cfg_lvl_pol),
    .cfg_submode(cfg_submode), .cfg_eof_sel(cfg_eof_sel), .cfg_len(cfg_len),
    .cfg_en_sel(cfg_en_sel), .cfg_to_en(cfg_to_en), .cfg_to_thresh(cfg_to_thresh),
    .sample_en(sample_en), .eof(eof), .err_eof(err_eof)
  );

  task automatic model_reset();
    m_st = 0; m_bytes = 0; m_idle = 0; m_seen = 0;
    m_mode = 0; m_pol = 0; m_sub = 0; m_esel = 0; m_len = 0;
    m_sel = 15; m_toen = 1; m_thr = 4095;
  endtask

  // One cycle: compare at mid-low phase, then advance the model at the edge.
  task automatic step(input string req);
    bit c, e, r, en, lh, th, hit, neg, sinc, einc, bylen, valid;
    int k;
    #1;
    c = 0; e = 0; r = 0;
    en = data_in[m_sel];
    lh = (m_bytes + 2) >= m_len;
    th = (m_idle + 1) >= m_thr;
    valid = (m_sub < 12);
    neg = valid && (m_sub >= 6);
    k = neg ? m_sub - 6 : m_sub;
    bylen = (k >= 4);
    sinc = bylen ? (k == 4) : (k < 2);
    einc = (k % 2) == 0;
    hit = en ^ neg;
    if (!arm && m_st != 0) begin
      if (m_mode == 0 || m_mode == 2) begin
        bit q;
        q = (m_mode == 0) ? (en ^ m_pol) : sw_en;
        c = q;
        e = m_esel ? (!q && m_seen) : (q && lh);
      end else if (m_mode == 1) begin
        if (m_st == 1) begin
          if (valid && hit) begin c = sinc; e = bylen && sinc && lh; end
        end else if (!bylen && hit) begin
          c = einc; e = 1;
        end else begin
          c = 1; e = bylen && lh;
        end
      end
      r = !c && !e && m_toen && th;
    end
    checks++;
    if ({sample_en, eof, err_eof} !== {c, e, r}) begin
      errors++;
      $display("FAIL %s: {sample_en,eof,err_eof} actual %b%b%b expected %b%b%b at %0t",
               req, sample_en, eof, err_eof, c, e, r, $time);
    end
    @(posedge clk);
    if (arm) begin
      m_st = 1; m_seen = 0; m_bytes = 0; m_idle = 0;
    end else if (m_st != 0) begin
      if (m_mode == 1 && m_st == 1 && valid && hit) m_st = 2;
      if (c) begin m_bytes += 2; m_idle = 0; m_seen = 1; end
      else if (m_idle < 65535) m_idle++;
      if (e || r) m_st = 0;
    end
    if (cfg_load) begin
      m_mode = cfg_mode; m_pol = cfg_lvl_pol; m_sub = cfg_submode;
      m_esel = cfg_eof_sel; m_len = cfg_len; m_sel = cfg_en_sel;
      m_toen = cfg_to_en; m_thr = cfg_to_thresh;
    end
    @(negedge clk);
    arm = 0; cfg_load = 0;
  endtask

  task automatic cyc(input logic [15:0] d, input string req);
    data_in = d;
    step(req);
  endtask

  task automatic load(input int mode, input bit pol, input int sub, input bit esel,
                      input int len, input int sel, input bit toen, input int thr);
    cfg_mode = 2'(mode); cfg_lvl_pol = pol; cfg_submode = 4'(sub);
    cfg_eof_sel = esel; cfg_len = 16'(len); cfg_en_sel = 4'(sel);
    cfg_to_en = toen; cfg_to_thresh = 16'(thr); cfg_load = 1;
    cyc(16'h0000, "R2");
  endtask

  task automatic start(input logic [15:0] d, input string req);
    arm = 1;
    cyc(d, req);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    cyc(16'h8000, "R1");
    rst_n = 1;
    cyc(16'h8000, "R1");
    cyc(16'hFFFF, "R1");

    // R2: unloaded fields have no effect; defaults are level/high/line 15
    cfg_mode = 2'd2; cfg_en_sel = 4'd0; cfg_eof_sel = 1'b1; cfg_len = 16'd2;
    start(16'h8000, "R1");
    cyc(16'h8001, "R2");
    cyc(16'h0001, "R2");
    cyc(16'h8000, "R2");
    cyc(16'h8000, "R8");
    cyc(16'h0000, "R1");

    // R3/R8: level, high polarity, end by length 6
    load(0, 0, 0, 0, 6, 15, 1, 100);
    start(16'h0000, "R12");
    cyc(16'h0000, "R3");
    cyc(16'h80A5, "R3");
    cyc(16'h005A, "R3");
    cyc(16'h8001, "R3");
    cyc(16'h8002, "R8");
    cyc(16'h8003, "R8");
    // R3/R9/R11: low polarity, end by enable, threshold 1 collides with eof
    load(0, 1, 0, 1, 0, 15, 1, 1);
    start(16'h8000, "R12");
    cyc(16'h0011, "R3");
    cyc(16'h0022, "R3");
    cyc(16'h8000, "R11");
    cyc(16'h0000, "R1");
    // R10: timeout with threshold 5
    load(0, 0, 0, 0, 10, 15, 1, 5);
    start(16'h0000, "R12");
    for (int i = 0; i < 7; i++) cyc(16'h7FFF, "R10");
    // R10: disabled timeout
    load(0, 0, 0, 0, 10, 15, 0, 2);
    start(16'h0000, "R12");
    for (int i = 0; i < 12; i++) cyc(16'h0000, "R10");
    // R4: software mode, length 4, then end by enable
    load(2, 0, 0, 0, 4, 15, 1, 50);
    start(16'h0000, "R12");
    sw_en = 1;
    cyc(16'h0000, "R4"); cyc(16'h0000, "R4"); cyc(16'h0000, "R8");
    load(2, 0, 0, 1, 0, 15, 1, 50);
    start(16'h8000, "R12");
    cyc(16'h8000, "R4");
    sw_en = 0;
    cyc(16'h8000, "R9");
    cyc(16'h8000, "R1");
    // R4: reserved mode never captures
    load(3, 0, 0, 0, 4, 15, 1, 3);
    start(16'h0000, "R12");
    sw_en = 1;
    for (int i = 0; i < 4; i++) cyc(16'hFFFF, "R4");
    sw_en = 0;
    // R13: enable line 3
    load(0, 0, 0, 0, 6, 3, 1, 100);
    start(16'h0000, "R12");
    cyc(16'h8000, "R13");
    cyc(16'h0008, "R13");
    cyc(16'hFFF7, "R13");
    cyc(16'h0008, "R13");
    cyc(16'h0008, "R8");
    // R5/R6/R7: all pulse submodes plus reserved ones
    for (int sub = 0; sub < 16; sub++) begin
      logic [15:0] on, off;
      string rq;
      on  = (sub >= 6 && sub < 12) ? 16'h0000 : 16'h8000;
      off = ~on & 16'h8000;
      rq  = (sub >= 12 || (sub % 6) >= 4) ? "R7" : "R6";
      load(1, 0, sub, 0, 6, 15, 1, 6);
      start(off, "R12");
      cyc(off | 16'h0001, "R5");
      cyc(on  | 16'h0002, "R5");
      cyc(off | 16'h0003, rq);
      cyc(off | 16'h0004, rq);
      cyc(on  | 16'h0005, rq);
      cyc(off | 16'h0006, rq);
      for (int i = 0; i < 6; i++) cyc(off, "R10");
    end
    // R11: excluded end pulse on the timeout cycle (threshold 1)
    load(1, 0, 1, 0, 6, 15, 1, 1);
    start(16'h8000, "R12");
    cyc(16'h0000, "R11");
    load(1, 0, 3, 0, 6, 15, 1, 2);
    start(16'h0000, "R12");
    cyc(16'h8000, "R5");
    cyc(16'h8000, "R11");
    cyc(16'h0000, "R1");
    // R12: re-arm mid-frame
    load(1, 0, 0, 0, 6, 15, 1, 20);
    start(16'h0000, "R12");
    cyc(16'h8000, "R5");
    cyc(16'h0001, "R6");
    start(16'h0002, "R12");
    cyc(16'h0003, "R12");
    cyc(16'h8004, "R12");
    cyc(16'h0005, "R6");
    cyc(16'h8006, "R6");
    cyc(16'h0000, "R1");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_500_000;
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule